// File: doc/BRIEF.md
# Interrupt Event Status and Mask Register Group

This block gathers three hardware event sources into a single interrupt line: an event from timer channel 0, an event from timer channel 1 and a counter overflow. A one-cycle pulse on any event input latches a raw status bit. Software reads the raw status, a mask and the masked status through a simple 32-bit register port. Four separate write-one-to-act registers set or clear bits of the raw status and of the mask. Writing a 0 to a bit of one of these registers leaves that bit unchanged.

The mask can also be written whole as an ordinary read/write register. A mask bit of 1 lets its source through and a mask bit of 0 blocks it. The interrupt line is a registered OR of the masked status. A clear of the raw status always works, including on a source that is masked. This allows a polling driver to run with every source masked.

The register port uses a word index (`regAddr`). A write is one cycle with `regWrEn` high. Read data is combinational from the current index.

Top module: `intevt_top`

## Requirements
- R1: After reset the mask, the raw status, the masked status and `irqOut` are all zero.
- R2: Sources sit at fixed bit positions: channel 0 at bit 0, channel 1 at bit 1, overflow at bit 6. Every other bit of every register reads as zero and cannot be set.
- R3: A one-cycle pulse on `ch0Evt`, `ch1Evt` or `ovfEvt` sets the matching raw status bit, visible on the first clock after the pulse. The bit stays set until software clears it.
- R4: Reading word 2 returns the bitwise AND of the mask (word 0) and the raw status (word 1).
- R5: Writing word 3 (status set) sets each raw status bit written as 1 and leaves bits written as 0 unchanged.
- R6: Writing word 4 (status clear) clears each raw status bit written as 1, whether or not that source is masked. Bits written as 0 are unchanged.
- R7: Writing word 5 (mask set) sets the mask bits written as 1. Writing word 6 (mask clear) clears the mask bits written as 1. Zero bits have no effect in both cases.
- R8: Word 0 is the mask as a read/write register. A write replaces it, with only bits 0, 1 and 6 kept.
- R9: When a hardware event and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R10: `irqOut` is the OR of the masked status bits and follows them one clock later.
- R11: Words 3 to 7 read as zero. Writes to words 1, 2 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| ch0Evt | input | 1 | Channel 0 event pulse |
| ch1Evt | input | 1 | Channel 1 event pulse |
| ovfEvt | input | 1 | Counter overflow event pulse |
| irqOut | output | 1 | Registered interrupt request |

## Verification
A corrupted raw status or mask bit shows on the read port at once, because reads of words 0 to 2 are combinational. It reaches `irqOut` one clock later, when the masked OR changes. A lost event pulse, or a clear that wins against a simultaneous event, shows as a missing raw bit on the first read after that edge. A mishandled reserved bit shows as a nonzero read of an unused position. The bench compares every read and `irqOut` against a behavioural model on every clock, so any such deviation is reported in the cycle where it first becomes visible.

// File: rtl/intevt_pkg.sv
package intevt_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 3;
  parameter int SRC_N  = 3;

  // Bit position of each source, index 0 = channel 0, 1 = channel 1, 2 = overflow
  localparam int SRC_POS [SRC_N] = '{0, 1, 6};

  localparam logic [ADDR_W-1:0] OFS_MASK    = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_RAW     = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MASKED  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_STATSET = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STATCLR = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_MASKSET = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MASKCLR = 3'd6;

  typedef enum logic [1:0] {RD_MASK, RD_RAW, RD_MASKED, RD_ZERO} rdSel_e;

  typedef struct packed {
    logic               wrMask;
    logic               setStat;
    logic               clrStat;
    logic               setMask;
    logic               clrMask;
    rdSel_e             rdSel;
    logic [DATA_W-1:0]  data;
  } strobe_t;

  function automatic logic [DATA_W-1:0] evtToBits(input logic [SRC_N-1:0] e);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < SRC_N; i++) v[SRC_POS[i]] = e[i];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] srcBits();
    return evtToBits('1);
  endfunction
endpackage

// File: rtl/intevt_ctrl.sv
module intevt_ctrl
  import intevt_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output strobe_t           stb
);
  localparam logic [DATA_W-1:0] KEEP = srcBits();

  always_comb begin
    stb         = '0;
    stb.data    = regWrData & KEEP;
    stb.wrMask  = regWrEn && (regAddr == OFS_MASK);
    stb.setStat = regWrEn && (regAddr == OFS_STATSET);
    stb.clrStat = regWrEn && (regAddr == OFS_STATCLR);
    stb.setMask = regWrEn && (regAddr == OFS_MASKSET);
    stb.clrMask = regWrEn && (regAddr == OFS_MASKCLR);
    unique case (regAddr)
      OFS_MASK:   stb.rdSel = RD_MASK;
      OFS_RAW:    stb.rdSel = RD_RAW;
      OFS_MASKED: stb.rdSel = RD_MASKED;
      default:    stb.rdSel = RD_ZERO;
    endcase
  end
endmodule

// File: rtl/intevt_dp.sv
module intevt_dp
  import intevt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SRC_N-1:0]  evtVec,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] rawQ,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] hwSet;
  logic [DATA_W-1:0] rawNext;
  logic [DATA_W-1:0] maskNext;

  always_comb begin
    hwSet = evtToBits(evtVec);

    rawNext = rawQ;
    if (stb.setStat) rawNext = rawNext | stb.data;
    if (stb.clrStat) rawNext = rawNext & ~stb.data;
    rawNext = rawNext | hwSet;  // hardware event wins over a clear

    maskNext = maskQ;
    if (stb.wrMask)  maskNext = stb.data;
    if (stb.setMask) maskNext = maskNext | stb.data;
    if (stb.clrMask) maskNext = maskNext & ~stb.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ   <= '0;
      maskQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      rawQ   <= rawNext;
      maskQ  <= maskNext;
      irqOut <= |(maskQ & rawQ);
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_MASK:   regRdData = maskQ;
      RD_RAW:    regRdData = rawQ;
      RD_MASKED: regRdData = maskQ & rawQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/intevt_top.sv
module intevt_top
  import intevt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              ch0Evt,
  input  logic              ch1Evt,
  input  logic              ovfEvt,
  output logic              irqOut
);
  strobe_t           stb;
  logic [SRC_N-1:0]  evtVec;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] rawQ;

  assign evtVec = {ovfEvt, ch1Evt, ch0Evt};

  intevt_ctrl u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .stb       (stb)
  );

  intevt_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .evtVec    (evtVec),
    .maskQ     (maskQ),
    .rawQ      (rawQ),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/intevt_chk.sv
module intevt_chk
  import intevt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [SRC_N-1:0]  evtVec,
  input logic [DATA_W-1:0] maskQ,
  input logic [DATA_W-1:0] rawQ,
  input logic              irqOut
);
  localparam logic [DATA_W-1:0] KEEP = srcBits();

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((rawQ & ~KEEP) == '0) && ((maskQ & ~KEEP) == '0));

  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec != '0) |=> ((rawQ & evtToBits($past(evtVec))) == evtToBits($past(evtVec))));

  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_STATCLR)
      |=> ((rawQ & $past(regWrData & KEEP & ~evtToBits(evtVec))) == '0));

  a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_STATCLR && evtVec != '0)
      |=> ((rawQ & evtToBits($past(evtVec))) == evtToBits($past(evtVec))));

  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_MASKSET)
      |=> ((maskQ & $past(regWrData & KEEP)) == $past(regWrData & KEEP)));

  a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_MASKCLR) |=> ((maskQ & $past(regWrData)) == '0));

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(maskQ & rawQ))));

  a_r11_raw_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFS_RAW && evtVec == '0) |=> $stable(rawQ));
endmodule

bind intevt_top intevt_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .evtVec    (evtVec),
  .maskQ     (maskQ),
  .rawQ      (rawQ),
  .irqOut    (irqOut)
);

// File: tb/sim_intevt_top.sv
`timescale 1ns/1ps
module sim_intevt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        ch0Evt = 1'b0, ch1Evt = 1'b0, ovfEvt = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mMask = '0, mRaw = '0;
  logic        mIrq = 1'b0;
  logic [31:0] lastRd;

  always #5 clk = ~clk;

  intevt_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ch0Evt(ch0Evt),
    .ch1Evt(ch1Evt), .ovfEvt(ovfEvt), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mMask;
      3'd1: return mRaw;
      3'd2: return mMask & mRaw;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd0: return "R8";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R11";
    endcase
  endfunction

  // ev bit0 = channel 0, bit1 = channel 1, bit2 = overflow
  task automatic step(input logic [2:0] a, input logic we, input logic [31:0] d, input logic [2:0] ev);
    logic [31:0] hw, keep, nr, nm;
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = d;
    {ovfEvt, ch1Evt, ch0Evt} = ev;
    #1;
    lastRd = regRdData;
    chk(tagFor(a), regRdData, mRead(a));
    chk("R10", {31'b0, irqOut}, {31'b0, mIrq});
    @(posedge clk);
    keep = 32'h43;
    hw = {25'b0, ev[2], 4'b0, ev[1], ev[0]};
    nr = mRaw; nm = mMask;
    if (we) begin
      case (a)
        3'd0: nm = d & keep;
        3'd3: nr = nr | (d & keep);
        3'd4: nr = nr & ~d;
        3'd5: nm = nm | (d & keep);
        3'd6: nm = nm & ~d;
        default: ;
      endcase
    end
    nr = nr | hw;
    mIrq = |(mMask & mRaw);
    mRaw = nr; mMask = nm;
  endtask

  task automatic expectRd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    step(a, 1'b0, 32'h0, 3'b000);
    chk(tag, lastRd, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    regAddr = 3'd0; #1 chk("R1", regRdData, 32'h0);
    regAddr = 3'd1; #1 chk("R1", regRdData, 32'h0);
    chk("R1", {31'b0, irqOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R8 / R2: direct mask write keeps only source bits
    step(3'd0, 1'b1, 32'hFFFF_FFFF, 3'b000);
    expectRd("R8", 3'd0, 32'h0000_0043);
    expectRd("R2", 3'd2, 32'h0);
    step(3'd0, 1'b1, 32'h0, 3'b000);
    expectRd("R8", 3'd0, 32'h0);

    // R3: event pulses latch, masked so no interrupt
    step(3'd1, 1'b0, 32'h0, 3'b001);
    expectRd("R3", 3'd1, 32'h0000_0001);
    step(3'd1, 1'b0, 32'h0, 3'b010);
    step(3'd1, 1'b0, 32'h0, 3'b100);
    expectRd("R3", 3'd1, 32'h0000_0043);
    chk("R10", {31'b0, irqOut}, 32'h0);

    // R6: clear while masked
    step(3'd4, 1'b1, 32'hFFFF_FFFF, 3'b000);
    expectRd("R6", 3'd1, 32'h0);

    // R5: status set, zero writes no effect
    step(3'd3, 1'b1, 32'hFFFF_FFBE, 3'b000);
    expectRd("R5", 3'd1, 32'h0000_0002);
    step(3'd3, 1'b1, 32'h0, 3'b000);
    expectRd("R5", 3'd1, 32'h0000_0002);

    // R7 / R4 / R10
    step(3'd5, 1'b1, 32'h0000_0040, 3'b000);
    expectRd("R7", 3'd0, 32'h0000_0040);
    expectRd("R4", 3'd2, 32'h0);
    step(3'd3, 1'b1, 32'h0000_0040, 3'b000);
    expectRd("R4", 3'd2, 32'h0000_0040);
    step(3'd1, 1'b0, 32'h0, 3'b000);
    chk("R10", {31'b0, irqOut}, 32'h1);

    // R9: event and clear on same bit
    step(3'd4, 1'b1, 32'h0000_0040, 3'b100);
    expectRd("R9", 3'd1, 32'h0000_0042);

    // R7 clear, R6 clear on now-masked source
    step(3'd6, 1'b1, 32'h0000_0040, 3'b000);
    expectRd("R7", 3'd0, 32'h0);
    step(3'd4, 1'b1, 32'h0000_0040, 3'b000);
    expectRd("R6", 3'd1, 32'h0000_0002);

    // R11: action words read zero, writes to read-only words ignored
    step(3'd5, 1'b1, 32'h0000_0003, 3'b000);
    for (int a = 3; a < 8; a++) expectRd("R11", a[2:0], 32'h0);
    step(3'd1, 1'b1, 32'hFFFF_FFFF, 3'b000);
    step(3'd2, 1'b1, 32'hFFFF_FFFF, 3'b000);
    step(3'd7, 1'b1, 32'hFFFF_FFFF, 3'b000);
    expectRd("R11", 3'd1, 32'h0000_0002);
    expectRd("R11", 3'd0, 32'h0000_0003);

    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0], r[3], $urandom, r[6:4] & {3{r[7] & r[8]}});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule